// File: doc/BRIEF.md
# Status Byte and Service Request Unit

This unit gathers the top-level status of an instrument into one 8-bit status byte and decides when the instrument must ask its controller for attention. Three summary inputs arrive from lower-level logic that is not part of this block: the operation-register summary, the event-status summary and the message-available flag. Four spare summary lines fill the low nibble. Each input is captured once per clock. Bit 6 of the byte is not captured from any input. It is the master summary of the other seven bits, each ANDed with its bit in an 8-bit request-enable mask.

A host reaches two registers through a small register port. Address 0 is the status byte, which is read-only and is never cleared by a read. Address 1 is the request-enable mask, which can be written and read back. A separate poll output always presents the same byte as a status read.

A request controller has two states. It leaves SRQ_QUIET for SRQ_REQUEST on a qualifying edge. A qualifying edge is an enabled status bit that is 0 in one captured sample and 1 in the next. The controller returns from SRQ_REQUEST to SRQ_QUIET once the master summary clears. Every qualifying edge also produces a one-cycle pulse, and the request level stays high while the controller is in SRQ_REQUEST and the master summary is still set.

Top module: `sb_status_unit`

## Requirements
- R1: After reset, the status byte reads 0x00, the enable mask reads 0x00, and both srq_pulse_o and srq_level_o are low.
- R2: One clock after they are sampled, the inputs appear in the status byte: oper_sum_i in bit 7, evt_sum_i in bit 5, mav_i in bit 4, and spare_i[3:0] in bits 3..0.
- R3: Bit 6 of the status byte is 1 exactly when one of bits 7, 5, 4, 3, 2, 1 or 0 is set and its bit in the enable mask is also set.
- R4: Bit 6 of a mask write is discarded. The mask reads back with bit 6 equal to 0, and an enable of bit 6 alone never sets the master summary.
- R5: Reading the status byte any number of times leaves it unchanged. A host write to address 0 has no effect.
- R6: srq_pulse_o is high for exactly one cycle after each capture in which an enabled status bit goes from 0 to 1. This also holds while a request is already standing.
- R7: No pulse and no request level come from a rise of a disabled bit, or from writing an enable bit for a status bit that is already set.
- R8: srq_level_o rises with a qualifying pulse. It stays high while the master summary stays set and falls in the cycle in which the master summary clears.
- R9: When a summary input returns to 0, because its underlying event register has been cleared, the matching status bit clears one clock later.
- R10: poll_byte_o always equals the value that a read of address 0 returns, including the live master summary in bit 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Active-low synchronous reset |
| oper_sum_i | input | 1 | Operation-register summary |
| evt_sum_i | input | 1 | Event-status summary |
| mav_i | input | 1 | Output buffer holds a readable response |
| spare_i | input | 4 | Spare summary lines for bits 3..0 |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | 1 | 0 = status byte, 1 = enable mask |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Read data for host_addr_i (combinational) |
| poll_byte_o | output | 8 | Status byte as returned by a poll |
| srq_pulse_o | output | 1 | One-cycle pulse per qualifying rising edge |
| srq_level_o | output | 1 | Standing service request |

## Verification
The assertions check four things on every cycle:
- the master summary agrees with the masked status bits;
- the mask never holds bit 6;
- a pulse only ever comes with an enabled bit that rose against the previous capture;
- the request level is never high without the master summary, and bit 7 follows the operation input with one clock of delay.

Other behaviour can only be shown by the bench's scenarios:
- reads leave the byte unchanged, and writes to the status address are dropped;
- enabling a bit that is already set raises no request;
- a second edge gives a second pulse while the level stands;
- clearing an input clears its bit.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int STB_W    = 8;
    localparam int OPER_BIT = 7;
    localparam int MSS_BIT  = 6;
    localparam int EVT_BIT  = 5;
    localparam int MAV_BIT  = 4;
    localparam int SPARE_W  = 4;

    localparam logic [STB_W-1:0] NO_MSS  = ~(STB_W'(1) << MSS_BIT);
    localparam logic [STB_W-1:0] MSS_ONE = STB_W'(1) << MSS_BIT;

    localparam logic ADDR_STB = 1'b0;
    localparam logic ADDR_SRE = 1'b1;

    typedef enum logic [0:0] {
        SRQ_QUIET   = 1'b0,
        SRQ_REQUEST = 1'b1
    } srq_state_e;
endpackage

// File: rtl/sb_stat_capture.sv
module sb_stat_capture
    import sb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               oper_sum_i,
    input  logic               evt_sum_i,
    input  logic               mav_i,
    input  logic [SPARE_W-1:0] spare_i,
    output logic [STB_W-1:0]   stat_q
);
    logic [STB_W-1:0] cap_d;

    // Spare lines fill the low bits one for one.
    for (genvar g = 0; g < SPARE_W; g++) begin : g_spare
        assign cap_d[g] = spare_i[g];
    end

    assign cap_d[MAV_BIT]  = mav_i;
    assign cap_d[EVT_BIT]  = evt_sum_i;
    assign cap_d[MSS_BIT]  = 1'b0;   // computed elsewhere, never captured
    assign cap_d[OPER_BIT] = oper_sum_i;

    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= cap_d;
    end
endmodule

// File: rtl/sb_enable_reg.sv
module sb_enable_reg
    import sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic             addr_i,
    input  logic [STB_W-1:0] wdata_i,
    output logic [STB_W-1:0] mask_q
);
    logic load;
    assign load = wr_i && (addr_i == ADDR_SRE);

    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (load) mask_q <= wdata_i & NO_MSS;
    end
endmodule

// File: rtl/sb_srq_engine.sv
module sb_srq_engine
    import sb_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [STB_W-1:0] stat_q,
    input  logic [STB_W-1:0] mask_q,
    output logic             mss_o,
    output logic             srq_pulse_o,
    output logic             srq_level_o
);
    srq_state_e       state_q, state_d;
    logic [STB_W-1:0] prev_q;
    logic [STB_W-1:0] rise;

    assign rise  = stat_q & ~prev_q & mask_q & NO_MSS;
    assign mss_o = |(stat_q & mask_q & NO_MSS);

    // State register and previous-sample register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SRQ_QUIET;
            prev_q  <= '0;
        end else begin
            state_q <= state_d;
            prev_q  <= stat_q;
        end
    end

    // Transitions: QUIET->REQUEST on a qualifying edge, REQUEST->QUIET when summary clears.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SRQ_QUIET:   if (|rise)  state_d = SRQ_REQUEST;
            SRQ_REQUEST: if (!mss_o) state_d = SRQ_QUIET;
            default:     state_d = SRQ_QUIET;
        endcase
    end

    // Outputs.
    always_comb begin
        srq_pulse_o = |rise;
        srq_level_o = srq_pulse_o;
        unique case (state_q)
            SRQ_QUIET:   srq_level_o = srq_pulse_o;
            SRQ_REQUEST: srq_level_o = srq_pulse_o | mss_o;
            default:     srq_level_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sb_status_unit.sv
module sb_status_unit
    import sb_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               oper_sum_i,
    input  logic               evt_sum_i,
    input  logic               mav_i,
    input  logic [SPARE_W-1:0] spare_i,
    input  logic               host_wr_i,
    input  logic               host_addr_i,
    input  logic [STB_W-1:0]   host_wdata_i,
    output logic [STB_W-1:0]   host_rdata_o,
    output logic [STB_W-1:0]   poll_byte_o,
    output logic               srq_pulse_o,
    output logic               srq_level_o
);
    logic [STB_W-1:0] stat_q;
    logic [STB_W-1:0] mask_q;
    logic             mss;

    sb_stat_capture u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .oper_sum_i (oper_sum_i),
        .evt_sum_i  (evt_sum_i),
        .mav_i      (mav_i),
        .spare_i    (spare_i),
        .stat_q     (stat_q)
    );

    sb_enable_reg u_sre (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (host_wr_i),
        .addr_i  (host_addr_i),
        .wdata_i (host_wdata_i),
        .mask_q  (mask_q)
    );

    sb_srq_engine u_srq (
        .clk         (clk),
        .rst_n       (rst_n),
        .stat_q      (stat_q),
        .mask_q      (mask_q),
        .mss_o       (mss),
        .srq_pulse_o (srq_pulse_o),
        .srq_level_o (srq_level_o)
    );

    assign poll_byte_o  = (stat_q & NO_MSS) | (mss ? MSS_ONE : '0);
    assign host_rdata_o = (host_addr_i == ADDR_SRE) ? mask_q : poll_byte_o;
endmodule

// File: rtl/sb_status_chk.sv
module sb_status_chk
    import sb_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             oper_sum_i,
    input logic [STB_W-1:0] poll_byte_o,
    input logic [STB_W-1:0] mask_q,
    input logic             srq_pulse_o,
    input logic             srq_level_o
);
    // R3: the summary bit agrees with the masked other bits
    a_r3_mss_summary: assert property (@(posedge clk) disable iff (!rst_n)
        poll_byte_o[MSS_BIT] == |(poll_byte_o & mask_q & NO_MSS));

    // R4: the mask never holds bit 6
    a_r4_mask_bit6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[MSS_BIT]);

    // R6: a pulse needs an enabled bit that rose since the previous capture
    a_r6_pulse_has_rise: assert property (@(posedge clk) disable iff (!rst_n)
        srq_pulse_o |-> |(poll_byte_o & ~$past(poll_byte_o) & mask_q & NO_MSS));

    // R8: no standing request without the master summary
    a_r8_level_needs_mss: assert property (@(posedge clk) disable iff (!rst_n)
        srq_level_o |-> poll_byte_o[MSS_BIT]);

    // R2: bit 7 follows the operation summary one clock later
    a_r2_oper_follows: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> poll_byte_o[OPER_BIT] == $past(oper_sum_i));
endmodule

bind sb_status_unit sb_status_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .oper_sum_i  (oper_sum_i),
    .poll_byte_o (poll_byte_o),
    .mask_q      (mask_q),
    .srq_pulse_o (srq_pulse_o),
    .srq_level_o (srq_level_o)
);

// File: tb/test_sb_status_unit.sv
`timescale 1ns/1ps
module test_sb_status_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       oper = 1'b0, evt = 1'b0, mav = 1'b0;
    logic [3:0] spare = 4'h0;
    logic       wr = 1'b0, addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata, poll;
    logic       pulse, level;
    int         n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;   // 125 MHz

    sb_status_unit i_sb_status_unit (
        .clk(clk), .rst_n(rst_n), .oper_sum_i(oper), .evt_sum_i(evt), .mav_i(mav),
        .spare_i(spare), .host_wr_i(wr), .host_addr_i(addr), .host_wdata_i(wdata),
        .host_rdata_o(rdata), .poll_byte_o(poll), .srq_pulse_o(pulse), .srq_level_o(level)
    );

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic a, input logic [7:0] d);
        wr = 1'b1; addr = a; wdata = d;
        tick();
        wr = 1'b0; addr = 1'b0;
        #1;
    endtask

    task automatic host_read(input logic a, output logic [7:0] d);
        addr = a; #1; d = rdata; addr = 1'b0; #1;
    endtask

    task automatic set_in(input logic o, input logic e, input logic m, input logic [3:0] s);
        oper = o; evt = e; mav = m; spare = s;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        host_read(1'b0, d); chk("R1 status", d, 8'h00);
        host_read(1'b1, d); chk("R1 mask", d, 8'h00);
        chk("R1 pulse/level", {6'd0, pulse, level}, 8'h00);
    endtask

    task automatic t_fields();
        set_in(1, 0, 1, 4'b0101); tick(); #1;
        chk("R2 pattern A", poll, 8'h95);
        set_in(0, 1, 0, 4'b1010); tick(); #1;
        chk("R2 pattern B", poll, 8'h2A);
    endtask

    task automatic t_mask_bit6();
        logic [7:0] d;
        host_write(1'b1, 8'hFF);
        host_read(1'b1, d); chk("R4 readback", d, 8'hBF);
        chk("R3 summary set", poll, 8'h6A);
        chk("R7 enable on set bit", {6'd0, pulse, level}, 8'h00);
        host_write(1'b1, 8'h40);
        host_read(1'b1, d); chk("R4 bit6 only readback", d, 8'h00);
        chk("R4 bit6 no summary", poll, 8'h2A);
    endtask

    task automatic t_no_clear();
        logic [7:0] d;
        for (int i = 0; i < 3; i++) begin
            host_read(1'b0, d); chk("R5 repeated read", d, 8'h2A);
            tick();
        end
        host_write(1'b0, 8'hFF);
        host_read(1'b0, d); chk("R5 write to status", d, 8'h2A);
        host_read(1'b1, d); chk("R5 mask untouched", d, 8'h00);
    endtask

    task automatic t_pulse_level();
        set_in(0, 0, 0, 4'h0); tick();
        host_write(1'b1, 8'h20); tick(); #1;
        evt = 1'b1; tick(); #1;
        chk("R6 pulse on edge", {6'd0, pulse, level}, 8'h03);
        chk("R3 poll", poll, 8'h60);
        tick(); #1;
        chk("R6 pulse one cycle / R8 level holds", {6'd0, pulse, level}, 8'h01);
        evt = 1'b0; tick(); #1;
        chk("R9 bit cleared", poll, 8'h00);
        chk("R8 level dropped", {6'd0, pulse, level}, 8'h00);
    endtask

    task automatic t_disabled();
        mav = 1'b1; tick(); #1;
        chk("R7 disabled rise", {6'd0, pulse, level}, 8'h00);
        chk("R2 mav bit", poll, 8'h10);
        evt = 1'b1; tick(); #1;
        chk("R6 enabled rise", {6'd0, pulse, level}, 8'h03);
        oper = 1'b1; tick(); #1;
        chk("R7 disabled rise while standing", {6'd0, pulse, level}, 8'h01);
        set_in(0, 0, 0, 4'h0); tick(); #1;
        chk("R9 all cleared", poll, 8'h00);
    endtask

    task automatic t_two_edges();
        logic [7:0] d;
        host_write(1'b1, 8'h90); tick(); #1;
        oper = 1'b1; tick(); #1;
        chk("R6 first edge", {6'd0, pulse, level}, 8'h03);
        tick(); #1;
        mav = 1'b1; tick(); #1;
        chk("R6 second edge while standing", {6'd0, pulse, level}, 8'h03);
        host_read(1'b0, d); chk("R10 poll equals read", poll, d);
        chk("R10 value", poll, 8'hD0);
        oper = 1'b0; tick(); #1;
        chk("R8 level held by other bit", {6'd0, pulse, level}, 8'h01);
        mav = 1'b0; tick(); #1;
        chk("R8 level released", {6'd0, pulse, level}, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        tick(); #1;
        t_reset();
        t_fields();
        t_mask_bit6();
        t_no_clear();
        t_pulse_level();
        t_disabled();
        t_two_edges();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule